// File: doc/BRIEF.md
# Planar video pixel shift unit

This block turns one fetch of four bit-plane bytes, all read from the same video memory address, into eight 4-bit colour indexes. A load strobe captures the four bytes together with the serialisation mode and the nibble direction. On every cycle with the pixel enable high, the output moves on by one pixel. The output stays put on other cycles, so a pixel can last for any number of pixel clocks.

Three serialisation patterns are available:
- Single shift: each pixel takes one bit from every plane.
- Interleaved: pixels are built from 2-bit pairs, first from planes 0 and 2, then from planes 1 and 3.
- 256-colour shift: each pixel is a 4-bit nibble taken from one plane at a time. The nibble order inside a byte is selectable.

When the eighth pixel reaches the output, the block pulses a request for the next fetch. A new load may arrive at any time and restarts the sequence at the first pixel.

Top module: `planar_pixel_shifter`

## Requirements
- R1: While reset is active (rst_n low, released through a two-stage synchroniser), pix_out is 0 and need_data is 0.
- R2: A load captures plane0..plane3, mode and lsb_first. Pixel 1 of the new data is on pix_out in the cycle after the loading edge, and this holds even if an earlier sequence is unfinished.
- R3: With mode 2'b00 (and the undefined code 2'b11), pixel k (k = 0..7) has bit n equal to bit 7-k of plane n.
- R4: With mode 2'b01, pixel k for k = 0..3 is {plane2[7-2k], plane2[6-2k], plane0[7-2k], plane0[6-2k]}. Pixels 4..7 follow the same pattern with plane 3 in place of plane 2 and plane 1 in place of plane 0, using j = k-4.
- R5: With mode 2'b10, pixels 2p and 2p+1 come from plane p. With lsb_first = 0 the order is bits [7:4] then [3:0]; with lsb_first = 1 it is [3:0] then [7:4].
- R6: A cycle with both pix_en and load low leaves pix_out unchanged.
- R7: need_data is high for exactly one cycle: the first cycle in which pixel 8 is on pix_out. It is raised only by a pix_en advance, never by a load.
- R8: Once pixel 8 has been advanced past, pix_out is 0, and further pix_en cycles keep it at 0 until the next load.
- R9: When load and pix_en are high together, the load wins: pixel 1 is shown and no advance takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture plane bytes, mode and direction |
| plane0 | input | 8 | Byte from bit plane 0 |
| plane1 | input | 8 | Byte from bit plane 1 |
| plane2 | input | 8 | Byte from bit plane 2 |
| plane3 | input | 8 | Byte from bit plane 3 |
| mode | input | 2 | Serialisation mode: 00 single, 01 interleaved, 10 256-colour, 11 as single |
| lsb_first | input | 1 | 256-colour nibble order: 0 high nibble first, 1 low nibble first |
| pix_en | input | 1 | Advance to the next pixel |
| pix_out | output | 4 | Current colour index |
| need_data | output | 1 | One-cycle request for the next plane fetch |

## Verification
A load is visible on pix_out one clock edge after it is sampled, and each enabled advance shows its pixel one edge later. need_data rises on the same edge that puts pixel 8 on the output. After rst_n goes high, the block accepts input only on the third rising edge. The bench therefore drives inputs on the falling edge and compares on the following falling edge. It inserts hold cycles and idle enables, and checks against values computed from the requirement formulas for every mode, direction and several byte patterns.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int PLANES       = 4;
  localparam int BYTE_W       = 8;
  localparam int PIX_W        = PLANES;
  localparam int PIX_PER_LOAD = BYTE_W;
  localparam int IDX_W        = $clog2(PIX_PER_LOAD);
  localparam int SYNC_STAGES  = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_NIBBLE = 2'b10,
    MODE_RSVD   = 2'b11
  } shift_mode_e;

  typedef logic [PLANES-1:0][BYTE_W-1:0] plane_set_t;
endpackage

// File: rtl/pxs_reset_sync.sv
module pxs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pxs_plane_store.sv
module pxs_plane_store
  import pxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  plane_set_t  planes_i,
  input  shift_mode_e mode_i,
  input  logic        lsb_first_i,
  output plane_set_t  planes_o,
  output shift_mode_e mode_o,
  output logic        lsb_first_o
);
  plane_set_t  planes_q, planes_d;
  shift_mode_e mode_q, mode_d;
  logic        dir_q, dir_d;

  always_comb begin
    planes_d = planes_q;
    mode_d   = mode_q;
    dir_d    = dir_q;
    if (load_i) begin
      planes_d = planes_i;
      mode_d   = mode_i;
      dir_d    = lsb_first_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      planes_q <= '0;
      mode_q   <= MODE_SINGLE;
      dir_q    <= 1'b0;
    end else begin
      planes_q <= planes_d;
      mode_q   <= mode_d;
      dir_q    <= dir_d;
    end
  end

  assign planes_o    = planes_q;
  assign mode_o      = mode_q;
  assign lsb_first_o = dir_q;
endmodule

// File: rtl/pxs_sequencer.sv
module pxs_sequencer
  import pxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             pix_en_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             active_o,
  output logic             need_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_LOAD - 1);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PIX_PER_LOAD - 2);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             act_q, act_d;
  logic             nd_q, nd_d;
  logic             advance;

  assign advance = pix_en_i && act_q && !load_i;

  always_comb begin
    idx_d = idx_q;
    act_d = act_q;
    nd_d  = 1'b0;
    if (load_i) begin
      idx_d = '0;
      act_d = 1'b1;
    end else if (advance) begin
      if (idx_q == LAST_IDX) begin
        idx_d = '0;
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        nd_d  = (idx_q == PRE_LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
      nd_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      act_q <= act_d;
      nd_q  <= nd_d;
    end
  end

  assign idx_o       = idx_q;
  assign active_o    = act_q;
  assign need_data_o = nd_q;
endmodule

// File: rtl/pxs_pixel_mux.sv
module pxs_pixel_mux
  import pxs_pkg::*;
(
  input  plane_set_t       planes_i,
  input  shift_mode_e      mode_i,
  input  logic             lsb_first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             active_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [IDX_W-1:0] rev_idx;
  logic [PIX_W-1:0] single_pix;
  logic [PIX_W-1:0] pair_pix;
  logic [PIX_W-1:0] nib_pix;
  logic [PIX_W-1:0] sel_pix;

  assign rev_idx = IDX_W'(PIX_PER_LOAD - 1) - idx_i;

  // Single shift: one bit per plane, plane n feeds bit n.
  for (genvar n = 0; n < PLANES; n++) begin : g_single
    assign single_pix[n] = planes_i[n][rev_idx];
  end

  // Interleaved: pairs from planes 0/2, then from planes 1/3.
  logic [1:0]       lo_plane, hi_plane;
  logic [1:0]       pair_no;
  logic [IDX_W-1:0] pos_hi, pos_lo;

  always_comb begin
    pair_no  = idx_i[1:0];
    lo_plane = {1'b0, idx_i[2]};
    hi_plane = {1'b1, idx_i[2]};
    pos_hi   = {~pair_no, 1'b1};
    pos_lo   = {~pair_no, 1'b0};
    pair_pix = {planes_i[hi_plane][pos_hi], planes_i[hi_plane][pos_lo],
                planes_i[lo_plane][pos_hi], planes_i[lo_plane][pos_lo]};
  end

  // 256-colour: a nibble per pixel, two pixels per plane.
  logic [1:0] nib_plane;
  logic       take_upper;

  always_comb begin
    nib_plane  = idx_i[2:1];
    take_upper = (idx_i[0] == lsb_first_i);
    nib_pix    = take_upper ? planes_i[nib_plane][BYTE_W-1 -: PIX_W]
                            : planes_i[nib_plane][PIX_W-1:0];
  end

  always_comb begin
    case (mode_i)
      MODE_PAIR:   sel_pix = pair_pix;
      MODE_NIBBLE: sel_pix = nib_pix;
      default:     sel_pix = single_pix;
    endcase
    pix_o = active_i ? sel_pix : '0;
  end
endmodule

// File: rtl/planar_pixel_shifter.sv
module planar_pixel_shifter
  import pxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BYTE_W-1:0] plane0,
  input  logic [BYTE_W-1:0] plane1,
  input  logic [BYTE_W-1:0] plane2,
  input  logic [BYTE_W-1:0] plane3,
  input  logic [1:0]       mode,
  input  logic             lsb_first,
  input  logic             pix_en,
  output logic [PIX_W-1:0] pix_out,
  output logic             need_data
);
  logic             rst_sync_n;
  plane_set_t       planes_in, planes_held;
  shift_mode_e      mode_held;
  logic             dir_held;
  logic [IDX_W-1:0] idx;
  logic             active;

  assign planes_in = {plane3, plane2, plane1, plane0};

  pxs_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pxs_plane_store u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (load),
    .planes_i    (planes_in),
    .mode_i      (shift_mode_e'(mode)),
    .lsb_first_i (lsb_first),
    .planes_o    (planes_held),
    .mode_o      (mode_held),
    .lsb_first_o (dir_held)
  );

  pxs_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (load),
    .pix_en_i    (pix_en),
    .idx_o       (idx),
    .active_o    (active),
    .need_data_o (need_data)
  );

  pxs_pixel_mux u_mux (
    .planes_i    (planes_held),
    .mode_i      (mode_held),
    .lsb_first_i (dir_held),
    .idx_i       (idx),
    .active_i    (active),
    .pix_o       (pix_out)
  );
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] plane0,
  input logic [7:0] plane1,
  input logic [7:0] plane2,
  input logic [7:0] plane3,
  input logic [1:0] mode,
  input logic       lsb_first,
  input logic       pix_en,
  input logic [3:0] pix_out,
  input logic       need_data
);
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pix_en) |=> $stable(pix_out)); // R6

  AST_SINGLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (mode == 2'b00 || mode == 2'b11)) |=>
      pix_out == {$past(plane3[7]), $past(plane2[7]), $past(plane1[7]), $past(plane0[7])}); // R3

  AST_PAIR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 2'b01) |=> pix_out == {$past(plane2[7:6]), $past(plane0[7:6])}); // R4

  AST_NIBBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 2'b10) |=>
      pix_out == ($past(lsb_first) ? $past(plane0[3:0]) : $past(plane0[7:4]))); // R5

  AST_NEED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    need_data |=> !need_data); // R7

  AST_NEED_FROM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    need_data |-> ($past(pix_en) && !$past(load))); // R7

  AST_LOAD_NO_NEED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !need_data); // R9
endmodule

bind planar_pixel_shifter pxs_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .load      (load),
  .plane0    (plane0),
  .plane1    (plane1),
  .plane2    (plane2),
  .plane3    (plane3),
  .mode      (mode),
  .lsb_first (lsb_first),
  .pix_en    (pix_en),
  .pix_out   (pix_out),
  .need_data (need_data)
);

// File: tb/planar_pixel_shifter_test.sv
`timescale 1ns/1ps
module planar_pixel_shifter_test;
  logic       clk = 1'b0;
  logic       rst_n, load, lsb_first, pix_en;
  logic [7:0] plane0, plane1, plane2, plane3;
  logic [1:0] mode;
  logic [3:0] pix_out;
  logic       need_data;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  planar_pixel_shifter uut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .plane0(plane0), .plane1(plane1), .plane2(plane2), .plane3(plane3),
    .mode(mode), .lsb_first(lsb_first), .pix_en(pix_en),
    .pix_out(pix_out), .need_data(need_data)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model(input logic [1:0] m, input logic d,
                                       input logic [7:0] b [4], input int k);
    logic [3:0] r;
    int lo, hi, j, p;
    bit upper;
    r = '0;
    if (m == 2'b01) begin
      lo = (k < 4) ? 0 : 1;
      hi = lo + 2;
      j  = k % 4;
      r[3] = b[hi][7-2*j];
      r[2] = b[hi][6-2*j];
      r[1] = b[lo][7-2*j];
      r[0] = b[lo][6-2*j];
    end else if (m == 2'b10) begin
      p = k / 2;
      upper = ((k % 2) == 0) == (d == 1'b0);
      r = upper ? b[p][7:4] : b[p][3:0];
    end else begin
      for (int n = 0; n < 4; n++) r[n] = b[n][7-k];
    end
    return r;
  endfunction

  function automatic string tag(input logic [1:0] m);
    if (m == 2'b01) return "R4";
    if (m == 2'b10) return "R5";
    return "R3";
  endfunction

  task automatic drive_load(input logic [1:0] m, input logic d,
                            input logic [7:0] b [4], input logic en);
    plane0 = b[0]; plane1 = b[1]; plane2 = b[2]; plane3 = b[3];
    mode = m; lsb_first = d; load = 1'b1; pix_en = en;
    step();
    load = 1'b0; pix_en = 1'b0;
    plane0 = ~b[0]; plane1 = ~b[1]; plane2 = ~b[2]; plane3 = ~b[3];
    mode = ~m; lsb_first = ~d;
  endtask

  task automatic run_pixels(input logic [1:0] m, input logic d,
                            input logic [7:0] b [4], input int hold_at);
    for (int k = 0; k < 8; k++) begin
      chk(tag(m), pix_out, model(m, d, b, k));
      chk("R7", {3'b0, need_data}, {3'b0, k == 7});
      if (k == hold_at) begin
        step();
        chk("R6", pix_out, model(m, d, b, k));
        chk("R7", {3'b0, need_data}, 4'd0);
      end
      pix_en = 1'b1;
      step();
      pix_en = 1'b0;
    end
    chk("R8", pix_out, 4'd0);
    chk("R7", {3'b0, need_data}, 4'd0);
    pix_en = 1'b1;
    step();
    pix_en = 1'b0;
    chk("R8", pix_out, 4'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] b [4];
    logic [7:0] c [4];
    logic [15:0] lfsr;
    rst_n = 1'b0; load = 1'b0; pix_en = 1'b0; mode = 2'b00; lsb_first = 1'b0;
    plane0 = 8'hFF; plane1 = 8'hFF; plane2 = 8'hFF; plane3 = 8'hFF;
    repeat (3) step();
    chk("R1", pix_out, 4'd0);
    chk("R1", {3'b0, need_data}, 4'd0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1", pix_out, 4'd0);

    lfsr = 16'hACE1;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int pat = 0; pat < 6; pat++) begin
          for (int n = 0; n < 4; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (pat)
              0: b[n] = 8'h01 << n;
              1: b[n] = 8'h80 >> n;
              2: b[n] = 8'hF0 ^ (8'h11 * n[7:0]);
              default: b[n] = lfsr[7:0] ^ lfsr[15:8];
            endcase
          end
          drive_load(m[1:0], d[0], b, 1'b0);
          run_pixels(m[1:0], d[0], b, (pat % 2 == 1) ? pat : -1);
        end
      end
    end

    // R2 / R9: reload mid-sequence with pix_en high
    b[0] = 8'h3C; b[1] = 8'hA5; b[2] = 8'h5A; b[3] = 8'hC3;
    c[0] = 8'h96; c[1] = 8'h0F; c[2] = 8'hE1; c[3] = 8'h78;
    drive_load(2'b01, 1'b0, b, 1'b0);
    chk("R2", pix_out, model(2'b01, 1'b0, b, 0));
    pix_en = 1'b1;
    repeat (3) step();
    pix_en = 1'b0;
    chk("R4", pix_out, model(2'b01, 1'b0, b, 3));
    drive_load(2'b10, 1'b1, c, 1'b1);
    chk("R9", pix_out, model(2'b10, 1'b1, c, 0));
    chk("R9", {3'b0, need_data}, 4'd0);
    run_pixels(2'b10, 1'b1, c, 7);

    // R1: asynchronous reset in the middle of a sequence
    drive_load(2'b00, 1'b0, c, 1'b0);
    pix_en = 1'b1;
    step();
    pix_en = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    chk("R1", pix_out, 4'd0);
    step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1", pix_out, 4'd0);
    chk("R1", {3'b0, need_data}, 4'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule